// File: doc/BRIEF.md
# LCD System-Bus Command Port

This block lets software drive a parallel system-bus LCD panel one bus cycle at a time. Software first loads a word into a register: a command/data word for a write, or an arming word for a read. It polls a busy flag until it reads zero. It then writes a trigger register, and the engine runs one panel bus cycle. Each cycle has a setup phase, a strobe phase and a hold phase, and every phase length is a parameter. The engine drives both panel chip selects, the register-select line, the write and read strobes and the outbound data bus. It also captures the data the panel returns.

Two panels share the bus: a main panel and a sub panel. Each trigger word picks the panel for that one cycle. A flag bit inside the write word decides whether the panel sees a command (index) cycle or a data cycle. At the moment of the trigger, the engine copies the word into a shadow register, so software may reload the write register while a cycle is still running. A trigger that arrives while a cycle is in progress is dropped and sets a sticky error flag.

Top module: `lcd_sbus_port`

## Requirements
- R1: After reset the status register reads 0, both chip selects and both strobes are high (inactive), the data bus is not driven (`lcd_d_oe`=0, `lcd_d_out`=0) and the read-data field reads 0.
- R2: A write to address 3 with bit 0 set, while idle and with bit 28 of the held write word set, starts a write cycle. A write to address 4 with bit 0 set, while idle and with bit 24 of the held read-arm word set, starts a read cycle. Status bit 1 (busy) reads 1 from the cycle after the trigger, for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC cycles, and then reads 0.
- R3: During a write cycle `lcd_rs` equals bit 24 of the held word (0 = index, 1 = data), and `lcd_d_out` carries its low 16 bits with `lcd_d_oe`=1 in every phase. During a read cycle `lcd_rs`=1 and `lcd_d_oe`=0.
- R4: Bit 1 of the trigger word selects the panel: 1 pulls `lcd_cs_sub_n` low and 0 pulls `lcd_cs_main_n` low, for the whole cycle. The two selects are never low together, and neither is low while idle.
- R5: The strobe (`lcd_wr_n` for writes, `lcd_rd_n` for reads) goes low after SETUP_CYC cycles and stays low for exactly STROBE_CYC cycles. The other strobe stays high.
- R6: A read captures `lcd_d_in` at the edge that ends the read strobe. The captured value then appears in bits 15:0 of address 1 and does not change until the next read capture, even when write cycles run in between.
- R7: A trigger (bit 0 set, at address 3 or 4) that is written while busy is set starts nothing, does not stretch the running cycle, and sets the sticky error flag, status bit 2. Writing address 2 with bit 2 set clears that flag.
- R8: The following triggers are ignored and leave the error flag clear: a trigger with bit 0 clear; a write trigger whose held word has bit 28 clear; a read trigger whose arm word has bit 24 clear.
- R9: Writes to the write-word register (address 0) during a cycle do not change `lcd_d_out` or `lcd_rs` for that cycle. The next trigger sends the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address (0 write word, 1 read arm/data, 2 status, 3 write trigger, 4 read trigger) |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` |
| lcd_cs_main_n | output | 1 | Main panel select, active low |
| lcd_cs_sub_n | output | 1 | Sub panel select, active low |
| lcd_rs | output | 1 | Register select, 0 index, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_d_out | output | 16 | Data driven to the panel |
| lcd_d_oe | output | 1 | Output enable for `lcd_d_out` |
| lcd_d_in | input | 16 | Data returned by the panel |

## Verification
A new trigger from software and the sequencer's return to idle can land in the same clock cycle. The bench provokes this by writing a trigger on the edge that ends the hold phase, when busy still reads 1. It expects that trigger to be rejected: busy must read 0 one cycle later, no strobe may follow, and the error flag must be set. A second collision, a reload of the write word in the first cycle of a running transfer, is judged by checking that the bus keeps the old word to the end of that cycle and carries the new word only on the next trigger.

// File: rtl/lcd_sbus_pkg.sv
package lcd_sbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  localparam int REG_AW = 3;
  localparam int WORD_W = 32;

  localparam logic [REG_AW-1:0] A_WWORD = 3'd0;
  localparam logic [REG_AW-1:0] A_RARM  = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] A_WTRIG = 3'd3;
  localparam logic [REG_AW-1:0] A_RTRIG = 3'd4;

  localparam int B_VALID = 28;  // write word must carry this bit
  localparam int B_DSEL  = 24;  // data (1) vs index (0); read arm flag
  localparam int B_GO    = 0;   // trigger start bit
  localparam int B_SUB   = 1;   // trigger panel select
  localparam int B_BUSY  = 1;   // status busy
  localparam int B_ERR   = 2;   // status sticky error

  typedef struct packed {
    logic rd;
    logic sub;
    logic rs;
  } cmd_t;

endpackage

// File: rtl/lcd_sbus_regs.sv
module lcd_sbus_regs
  import lcd_sbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_capture,
  output logic              go,
  output cmd_t              go_cmd,
  output logic [DATA_W-1:0] go_data
);

  logic [WORD_W-1:0] wword_q, wword_d;
  logic              wword_en;
  logic              rarm_q, rarm_d, rarm_en;
  logic              err_q, err_d, err_en;
  logic              trig_w, trig_r, trig_any;

  always_comb begin
    trig_w   = cpu_we && (cpu_addr == A_WTRIG) && cpu_wdata[B_GO];
    trig_r   = cpu_we && (cpu_addr == A_RTRIG) && cpu_wdata[B_GO];
    trig_any = trig_w || trig_r;

    go = !busy && ((trig_w && wword_q[B_VALID]) || (trig_r && rarm_q));
    go_cmd.rd  = trig_r;
    go_cmd.sub = cpu_wdata[B_SUB];
    go_cmd.rs  = trig_r ? 1'b1 : wword_q[B_DSEL];
    go_data    = wword_q[DATA_W-1:0];

    wword_en = cpu_we && (cpu_addr == A_WWORD);
    wword_d  = cpu_wdata;
    rarm_en  = cpu_we && (cpu_addr == A_RARM);
    rarm_d   = cpu_wdata[B_DSEL];

    err_en = 1'b0;
    err_d  = err_q;
    if (trig_any && busy) begin
      err_en = 1'b1;
      err_d  = 1'b1;
    end else if (cpu_we && (cpu_addr == A_STAT) && cpu_wdata[B_ERR]) begin
      err_en = 1'b1;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wword_q <= '0;
      rarm_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wword_en) wword_q <= wword_d;
      if (rarm_en)  rarm_q  <= rarm_d;
      if (err_en)   err_q   <= err_d;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      A_WWORD: cpu_rdata = wword_q;
      A_RARM: begin
        cpu_rdata[DATA_W-1:0] = rd_capture;
        cpu_rdata[B_DSEL]     = rarm_q;
      end
      A_STAT: begin
        cpu_rdata[B_BUSY] = busy;
        cpu_rdata[B_ERR]  = err_q;
      end
      default: cpu_rdata = '0;
    endcase
  end

  // R7: a start request that collides with a running cycle raises the error flag
  assert_err_on_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && (cpu_addr == A_WTRIG || cpu_addr == A_RTRIG) && cpu_wdata[B_GO] && busy)
      |=> (cpu_rdata[B_ERR] || cpu_addr != A_STAT) && err_q);

endmodule

// File: rtl/lcd_sbus_seq.sv
module lcd_sbus_seq
  import lcd_sbus_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  cmd_t              go_cmd,
  input  logic [DATA_W-1:0] go_data,
  output logic              busy,
  output logic [DATA_W-1:0] rd_capture,
  output logic              lcd_cs_main_n,
  output logic              lcd_cs_sub_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [DATA_W-1:0] lcd_d_out,
  output logic              lcd_d_oe,
  input  logic [DATA_W-1:0] lcd_d_in
);

  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_t              cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q, dat_d, cap_q, cap_d;
  logic              load_en, cap_en, last;

  always_comb begin
    last    = (cnt_q == '0);
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (go) begin
        ph_d    = PH_SETUP;
        cnt_d   = SETUP_LD;
        load_en = 1'b1;
      end
      PH_SETUP: if (last) begin
        ph_d  = PH_STROBE;
        cnt_d = STROBE_LD;
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (last) begin
        ph_d   = PH_HOLD;
        cnt_d  = HOLD_LD;
        cap_en = cmd_q.rd;
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (last) ph_d = PH_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
    cmd_d = go_cmd;
    dat_d = go_data;
    cap_d = lcd_d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      cmd_q <= '0;
      dat_q <= '0;
      cap_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (load_en) begin
        cmd_q <= cmd_d;
        dat_q <= dat_d;
      end
      if (cap_en) cap_q <= cap_d;
    end
  end

  always_comb begin
    busy          = (ph_q != PH_IDLE);
    rd_capture    = cap_q;
    lcd_cs_main_n = !(busy && !cmd_q.sub);
    lcd_cs_sub_n  = !(busy && cmd_q.sub);
    lcd_rs        = busy && cmd_q.rs;
    lcd_wr_n      = !((ph_q == PH_STROBE) && !cmd_q.rd);
    lcd_rd_n      = !((ph_q == PH_STROBE) && cmd_q.rd);
    lcd_d_oe      = busy && !cmd_q.rd;
    lcd_d_out     = lcd_d_oe ? dat_q : '0;
  end

  // R4: never both panels selected
  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_cs_main_n && !lcd_cs_sub_n));

  // R5: write and read strobes never overlap, and a strobe only within a select
  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n || !lcd_rd_n) |-> (!(!lcd_wr_n && !lcd_rd_n) && !(lcd_cs_main_n && lcd_cs_sub_n)));

  // R9: bus contents frozen for the length of one cycle
  assert_bus_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lcd_d_out) && $stable(lcd_rs) && $stable(lcd_cs_sub_n)));

  // R6: captured read data only moves when a read strobe ends
  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcd_rd_n == 1'b0 && ph_d == PH_HOLD) |=> $stable(rd_capture));

endmodule

// File: rtl/lcd_sbus_port.sv
module lcd_sbus_port
  import lcd_sbus_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              lcd_cs_main_n,
  output logic              lcd_cs_sub_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [DATA_W-1:0] lcd_d_out,
  output logic              lcd_d_oe,
  input  logic [DATA_W-1:0] lcd_d_in
);

  logic              rst_meta, rst_s;
  logic              go, busy;
  cmd_t              go_cmd;
  logic [DATA_W-1:0] go_data, rd_capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  lcd_sbus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .busy       (busy),
    .rd_capture (rd_capture),
    .go         (go),
    .go_cmd     (go_cmd),
    .go_data    (go_data)
  );

  lcd_sbus_seq #(
    .DATA_W     (DATA_W),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_s),
    .go            (go),
    .go_cmd        (go_cmd),
    .go_data       (go_data),
    .busy          (busy),
    .rd_capture    (rd_capture),
    .lcd_cs_main_n (lcd_cs_main_n),
    .lcd_cs_sub_n  (lcd_cs_sub_n),
    .lcd_rs        (lcd_rs),
    .lcd_wr_n      (lcd_wr_n),
    .lcd_rd_n      (lcd_rd_n),
    .lcd_d_out     (lcd_d_out),
    .lcd_d_oe      (lcd_d_oe),
    .lcd_d_in      (lcd_d_in)
  );

  // R2: an accepted start shows up as busy on the following cycle
  assert_busy_after_go_R2: assert property (@(posedge clk) disable iff (!rst_s)
    go |=> busy);

  // R1: idle means an undriven, deselected bus
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> (lcd_cs_main_n && lcd_cs_sub_n && lcd_wr_n && lcd_rd_n && !lcd_d_oe));

endmodule

// File: tb/lcd_sbus_port_tb.sv
module lcd_sbus_port_tb;

  localparam int S  = 2;
  localparam int ST = 3;
  localparam int H  = 1;
  localparam int T  = S + ST + H;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [2:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cs_m_n, cs_s_n, rs, wr_n, rd_n, d_oe;
  logic [15:0] d_out, d_in, panel_val;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign d_in = rd_n ? 16'h5A5A : panel_val;

  lcd_sbus_port #(.DATA_W(16), .SETUP_CYC(S), .STROBE_CYC(ST), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .lcd_cs_main_n(cs_m_n), .lcd_cs_sub_n(cs_s_n), .lcd_rs(rs),
    .lcd_wr_n(wr_n), .lcd_rd_n(rd_n), .lcd_d_out(d_out), .lcd_d_oe(d_oe),
    .lcd_d_in(d_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [31:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  function automatic logic [31:0] wword(input bit idx, input logic [15:0] pay);
    return 32'h1000_0000 | (idx ? 32'h0 : 32'h0100_0000) | {16'h0, pay};
  endfunction

  // runs one cycle and checks every phase; entry/exit at a falling edge
  task automatic xfer(input bit rd, input bit sub, input bit idx,
                      input logic [15:0] pay, input logic [15:0] pv);
    int bad_strobe = 0, bad_sel = 0, bad_bus = 0, bad_busy = 0;
    logic [31:0] r;
    if (rd) begin
      cpu_write(3'd1, 32'h0100_0000);
      panel_val = pv;
    end else begin
      cpu_write(3'd0, wword(idx, pay));
    end
    cpu_write(rd ? 3'd4 : 3'd3, {30'h0, sub, 1'b1});
    for (int i = 0; i < T; i++) begin
      bit in_st = (i >= S) && (i < S + ST);
      cpu_read(3'd2, r);
      if (r[1] !== 1'b1) bad_busy++;
      if (wr_n !== !(in_st && !rd) || rd_n !== !(in_st && rd)) bad_strobe++;
      if (cs_m_n !== sub || cs_s_n !== !sub) bad_sel++;
      if (rs !== (rd ? 1'b1 : !idx) || d_oe !== !rd || d_out !== (rd ? 16'h0 : pay)) bad_bus++;
      @(negedge clk);
    end
    chk("R2 busy held for whole cycle", bad_busy, 0);
    chk("R5 strobe timing", bad_strobe, 0);
    chk("R4 panel select", bad_sel, 0);
    chk("R3 rs/data/oe", bad_bus, 0);
    cpu_read(3'd2, r);
    chk("R2 busy clears after hold", r[1], 1'b0);
    chk("R1 idle bus quiet", {cs_m_n, cs_s_n, wr_n, rd_n, d_oe}, 5'b11110);
    if (rd) begin
      cpu_read(3'd1, r);
      chk("R6 captured read data", {r[31:25], r[23:0]}, {7'h0, 8'h0, pv});
    end
  endtask

  initial begin
    logic [31:0] r;
    logic [15:0] last_pv;
    int unsigned seed;
    cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; panel_val = 16'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cpu_read(3'd2, r);  chk("R1 status after reset", r, 32'h0);
    cpu_read(3'd1, r);  chk("R1 read data after reset", r, 32'h0);
    chk("R1 pins after reset", {cs_m_n, cs_s_n, wr_n, rd_n, d_oe, d_out}, {5'b11110, 16'h0});

    // directed transfers
    xfer(0, 0, 1, 16'h00A5, 16'h0);
    xfer(0, 1, 0, 16'hBEEF, 16'h0);
    xfer(1, 1, 0, 16'h0, 16'hC3D2);
    xfer(1, 0, 0, 16'h0, 16'h1234);
    last_pv = 16'h1234;

    // R6 capture holds through write cycles
    xfer(0, 0, 0, 16'h7777, 16'h0);
    cpu_read(3'd1, r);
    chk("R6 read data stable across writes", r[15:0], last_pv);

    // R7 trigger while busy, early in the cycle
    begin
      int n = 1;
      cpu_write(3'd0, wword(0, 16'h4242));
      cpu_write(3'd3, 32'h1);
      cpu_write(3'd3, 32'h3);
      cpu_read(3'd2, r);
      while (r[1] === 1'b1 && n < 50) begin
        n++;
        @(negedge clk);
        cpu_read(3'd2, r);
      end
      chk("R7 busy length not stretched", n, T);
      chk("R7 error flag set", r[2], 1'b1);
      chk("R7 no follow-on cycle", {cs_m_n, cs_s_n}, 2'b11);
    end
    cpu_write(3'd2, 32'h4);
    cpu_read(3'd2, r);
    chk("R7 error cleared by status write", r[2], 1'b0);

    // R7 trigger in the final hold cycle (race with return to idle)
    cpu_write(3'd3, 32'h1);
    repeat (T - 1) @(negedge clk);
    cpu_write(3'd4, 32'h1);
    cpu_read(3'd2, r);
    chk("R7 late trigger rejected: busy", r[1], 1'b0);
    chk("R7 late trigger rejected: error", r[2], 1'b1);
    @(negedge clk);
    chk("R7 late trigger: no strobe", {wr_n, rd_n, cs_m_n, cs_s_n}, 4'b1111);
    cpu_write(3'd2, 32'h4);

    // R8 ignored triggers
    cpu_write(3'd3, 32'h2);
    cpu_read(3'd2, r);
    chk("R8 go bit clear ignored", r, 32'h0);
    cpu_write(3'd0, 32'h0100_1111);
    cpu_write(3'd3, 32'h1);
    cpu_read(3'd2, r);
    chk("R8 word without valid bit ignored", r, 32'h0);
    chk("R8 bus untouched", {cs_m_n, cs_s_n, d_oe}, 3'b110);
    cpu_write(3'd1, 32'h0);
    cpu_write(3'd4, 32'h1);
    cpu_read(3'd2, r);
    chk("R8 unarmed read ignored", r, 32'h0);
    cpu_read(3'd1, r);
    chk("R8 unarmed read keeps data", r[15:0], last_pv);

    // R9 reload during a cycle
    begin
      int bad = 0;
      cpu_write(3'd0, wword(0, 16'hAAAA));
      cpu_write(3'd3, 32'h1);
      cpu_write(3'd0, wword(1, 16'h5555));
      for (int i = 1; i < T; i++) begin
        if (d_out !== 16'hAAAA || rs !== 1'b1) bad++;
        @(negedge clk);
      end
      chk("R9 bus frozen during reload", bad, 0);
      cpu_write(3'd3, 32'h1);
      chk("R9 next cycle sends new word", {rs, d_out}, {1'b0, 16'h5555});
      repeat (T) @(negedge clk);
    end

    // constrained random mix
    seed = $urandom(32'd2024);
    for (int k = 0; k < 40; k++) begin
      bit rd  = $urandom_range(0, 2) == 0;
      bit sub = $urandom_range(0, 1) == 1;
      bit idx = $urandom_range(0, 1) == 1;
      logic [15:0] pay = 16'($urandom);
      logic [15:0] pv  = 16'($urandom);
      xfer(rd, sub, idx, pay, pv);
      if (rd) last_pv = pv;
    end
    cpu_read(3'd1, r);
    chk("R6 final read data", r[15:0], last_pv);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule